// File: doc/BRIEF.md
# Trace Vector Run-Length Compressor

This block compresses the stream of trace vectors sampled from a set of observed flip-flops before they are written into an on-chip trace buffer. Each accepted vector is first reordered by a bit mapping supplied as configuration. It is then replaced by its XOR with the previously accepted vector. The result is shifted out one bit per cycle, and the shift direction flips on every second vector. The resulting serial stream is coded with a frequency-directed run-length code, in which a run of zeros closed by a one becomes one variable-length codeword. Codeword bits are packed into fixed-width words for the buffer's write port.

The serial path handles one bit per cycle and a codeword takes several cycles, so a small vector queue and a ready/valid handshake hold the capture source back when the coder falls behind. No accepted vector is lost. When capture ends, a flush request drains the queue and codes the open run. It emits the last partial word padded with zeros, together with its count of valid bits and a flag saying whether the final closing one is virtual. After a flush the block starts a fresh session: the next vector is not differenced and the direction sequence restarts.

Top module: `trace_fdr_compressor`

## Requirements
- R1: After synchronous reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Bit i of the internal vector equals `trace_in[m]`, where m is the unsigned field `perm_map[i*IDX_W +: IDX_W]`.
- R3: The first vector accepted after reset or after a completed flush passes unchanged. Every later vector is XORed with the previous mapped vector.
- R4: Within a session, vectors 0, 2, 4, ... are serialized from bit 0 upward, and vectors 1, 3, ... from bit VEC_W-1 downward.
- R5: A run of r zeros closed by a one is coded in group k = floor(log2(r+2)) as k-1 ones, then a zero, then r+2-2^k in k bits with the MSB first.
- R6: When a run reaches RUN_CAP = 2^CNT_W-3 zeros, the block emits the codeword for RUN_CAP at once. That codeword stands for RUN_CAP zeros with no closing one, and counting restarts from zero.
- R7: Codeword bits fill `out_word` from bit WORD_W-1 downward. Every word that is not the last of a session carries `out_cnt` = WORD_W.
- R8: On flush, a nonzero open run is coded as if closed by a one. The last word has `out_last`=1, zero padding below its `out_cnt` valid bits, and `out_virt`=1 exactly when such an open run was coded.
- R9: A vector is taken only when `in_valid` and `in_ready` are both 1. `in_ready` is 0 while the queue is full and from the cycle after a flush request until the flush ends.
- R10: Decoding the word stream and undoing reversal, differencing and mapping gives back every accepted vector, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| perm_map | input | VEC_W*IDX_W | Source flop index for each vector bit |
| trace_in | input | VEC_W | Raw sampled trace flops |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Sample will be taken this cycle |
| flush_req | input | 1 | One-cycle pulse: capture ended |
| out_word | output | WORD_W | Packed codeword bits, MSB first |
| out_valid | output | 1 | out_word is written this cycle |
| out_cnt | output | OCNT_W | Number of valid bits in out_word |
| out_last | output | 1 | Final word of the session |
| out_virt | output | 1 | Final closing one is virtual |

## Verification
The bench builds the block with VEC_W=8, WORD_W=16, CNT_W=5 and a two-entry queue. These values give RUN_CAP=29 and codewords of at most 8 bits. A few all-zero vectors therefore cross the saturation point, and short directed traces fit in a single hand-computed output word. Eight-bit vectors shifted out one bit per cycle cannot keep pace with back-to-back input, so the queue fills and backpressure occurs in every streaming test. The 16-bit word lets multi-word sessions exercise both full-word and partial-word packing.

// File: rtl/trc_pkg.sv
package trc_pkg;

    typedef enum logic [2:0] {
        FL_IDLE,
        FL_DRAIN,
        FL_VIRT,
        FL_WAIT,
        FL_FINAL
    } flush_state_t;

    // group index k of a run length r: largest k with 2^k <= r+2
    function automatic int fdr_group(input int r);
        int g;
        g = 1;
        for (int k = 1; k < 31; k++) begin
            if (r + 2 >= (1 << k)) g = k;
        end
        return g;
    endfunction

    // right-aligned codeword value; its length is 2*fdr_group(r)
    function automatic int fdr_value(input int r);
        int k;
        int tail;
        k    = fdr_group(r);
        tail = r + 2 - (1 << k);
        return (((1 << (k - 1)) - 1) << (k + 1)) | tail;
    endfunction

endpackage

// File: rtl/trc_prep.sv
module trc_prep #(
    parameter int VEC_W = 8,
    parameter int IDX_W = $clog2(VEC_W)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [VEC_W*IDX_W-1:0] perm_map,
    input  logic [VEC_W-1:0]       trace_in,
    input  logic                   take,
    input  logic                   clr,
    output logic [VEC_W-1:0]       diff_vec
);
    logic [VEC_W-1:0] mapped;
    logic [VEC_W-1:0] prev_q;
    logic             first_q;

    always_comb begin
        for (int i = 0; i < VEC_W; i++) begin
            mapped[i] = trace_in[perm_map[i*IDX_W +: IDX_W]];
        end
    end

    assign diff_vec = first_q ? mapped : (mapped ^ prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            first_q <= 1'b1;
        end else if (clr) begin
            first_q <= 1'b1;
        end else if (take) begin
            prev_q  <= mapped;
            first_q <= 1'b0;
        end
    end

    assert_first_after_clr_R3: assert property (@(posedge clk) disable iff (rst)
        clr |=> first_q);
    assert_first_cleared_R3: assert property (@(posedge clk) disable iff (rst)
        (take && !clr) |=> !first_q);

endmodule

// File: rtl/trc_fifo.sv
module trc_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count;

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign rdata = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= wdata;
                wr_ptr      <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/trc_ser.sv
module trc_ser #(
    parameter int VEC_W = 8,
    parameter int IDX_W = $clog2(VEC_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VEC_W-1:0] vec_in,
    input  logic             vec_avail,
    output logic             vec_pop,
    input  logic             clr,
    output logic             busy,
    output logic             bit_valid,
    output logic             bit_out,
    input  logic             bit_ready
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(VEC_W - 1);

    logic [VEC_W-1:0] vec_q;
    logic [IDX_W-1:0] pos_q;
    logic [IDX_W-1:0] done_q;
    logic             rev_q;
    logic             last_take;

    assign vec_pop   = !busy && vec_avail;
    assign bit_valid = busy;
    assign bit_out   = vec_q[pos_q];
    assign last_take = busy && bit_ready && (done_q == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            vec_q  <= '0;
            pos_q  <= '0;
            done_q <= '0;
            rev_q  <= 1'b0;
        end else begin
            if (vec_pop) begin
                busy   <= 1'b1;
                vec_q  <= vec_in;
                pos_q  <= rev_q ? TOP : '0;
                done_q <= '0;
            end else if (busy && bit_ready) begin
                if (done_q == TOP) begin
                    busy  <= 1'b0;
                    rev_q <= ~rev_q;
                end else begin
                    pos_q  <= rev_q ? pos_q - 1'b1 : pos_q + 1'b1;
                    done_q <= done_q + 1'b1;
                end
            end
            if (clr) rev_q <= 1'b0;
        end
    end

    assert_parity_step_R4: assert property (@(posedge clk) disable iff (rst)
        (rev_q != $past(rev_q)) |-> $past(last_take || clr));
    assert_clr_idle_R4: assert property (@(posedge clk) disable iff (rst)
        clr |-> !busy);

endmodule

// File: rtl/trc_fdr_enc.sv
module trc_fdr_enc
    import trc_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic bit_in,
    output logic bit_ready,
    input  logic flush_go,
    output logic run_pending,
    output logic pbit_valid,
    output logic pbit
);
    localparam int GMAX    = CNT_W - 1;
    localparam int CW_W    = 2 * GMAX;
    localparam int LEFT_W  = $clog2(CW_W + 1);
    localparam int RUN_CAP = (1 << CNT_W) - 3;

    logic [CNT_W-1:0]  run_q;
    logic [CW_W-1:0]   cw_q;
    logic [LEFT_W-1:0] left_q;
    logic              load;
    int                load_run;

    function automatic logic [CW_W-1:0] cw_aligned(input int r);
        int k;
        k = fdr_group(r);
        return CW_W'(fdr_value(r) << (CW_W - 2 * k));
    endfunction

    assign bit_ready   = (left_q == '0);
    assign pbit_valid  = (left_q != '0);
    assign pbit        = cw_q[CW_W-1];
    assign run_pending = (run_q != '0);

    always_comb begin
        load     = 1'b0;
        load_run = 0;
        if (flush_go) begin
            load     = run_pending;
            load_run = int'(run_q);
        end else if (bit_valid && bit_ready) begin
            if (bit_in) begin
                load     = 1'b1;
                load_run = int'(run_q);
            end else if (run_q == CNT_W'(RUN_CAP - 1)) begin
                load     = 1'b1;
                load_run = RUN_CAP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            cw_q   <= '0;
            left_q <= '0;
        end else begin
            if (load) begin
                cw_q   <= cw_aligned(load_run);
                left_q <= LEFT_W'(2 * fdr_group(load_run));
            end else if (left_q != '0) begin
                cw_q   <= cw_q << 1;
                left_q <= left_q - 1'b1;
            end
            if (flush_go || (bit_valid && bit_ready && (bit_in || load))) begin
                run_q <= '0;
            end else if (bit_valid && bit_ready) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assert_run_below_cap_R6: assert property (@(posedge clk) disable iff (rst)
        run_q < CNT_W'(RUN_CAP));
    assert_flush_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        flush_go |-> (bit_ready && !bit_valid));
    assert_cw_even_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(pbit_valid) |-> !left_q[0]);

endmodule

// File: rtl/trc_pack.sv
module trc_pack #(
    parameter int WORD_W = 16,
    parameter int OCNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pbit_valid,
    input  logic              pbit,
    input  logic              fin,
    input  logic              fin_virt,
    output logic [WORD_W-1:0] out_word,
    output logic              out_valid,
    output logic [OCNT_W-1:0] out_cnt,
    output logic              out_last,
    output logic              out_virt
);
    logic [WORD_W-1:0] acc_q;
    logic [OCNT_W-1:0] fill_q;
    logic [WORD_W-1:0] acc_nx;
    logic              word_done;

    always_comb begin
        acc_nx = acc_q;
        acc_nx[WORD_W - 1 - int'(fill_q)] = pbit;
        word_done = (fill_q == OCNT_W'(WORD_W - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            fill_q    <= '0;
            out_word  <= '0;
            out_valid <= 1'b0;
            out_cnt   <= '0;
            out_last  <= 1'b0;
            out_virt  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_virt  <= 1'b0;
            if (fin) begin
                out_word  <= acc_q;
                out_cnt   <= fill_q;
                out_valid <= 1'b1;
                out_last  <= 1'b1;
                out_virt  <= fin_virt;
                acc_q     <= '0;
                fill_q    <= '0;
            end else if (pbit_valid) begin
                if (word_done) begin
                    out_word  <= acc_nx;
                    out_cnt   <= OCNT_W'(WORD_W);
                    out_valid <= 1'b1;
                    acc_q     <= '0;
                    fill_q    <= '0;
                end else begin
                    acc_q  <= acc_nx;
                    fill_q <= fill_q + 1'b1;
                end
            end
        end
    end

    assert_full_words_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |-> (out_cnt == OCNT_W'(WORD_W)));
    assert_fin_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        fin |-> !pbit_valid);
    assert_last_short_R8: assert property (@(posedge clk) disable iff (rst)
        out_last |-> (out_cnt < OCNT_W'(WORD_W)));

endmodule

// File: rtl/trace_fdr_compressor.sv
module trace_fdr_compressor
    import trc_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int WORD_W = 16,
    parameter int CNT_W  = 5,
    parameter int FIFO_D = 2,
    parameter int IDX_W  = $clog2(VEC_W),
    parameter int OCNT_W = $clog2(WORD_W + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [VEC_W*IDX_W-1:0] perm_map,
    input  logic [VEC_W-1:0]       trace_in,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic                   flush_req,
    output logic [WORD_W-1:0]      out_word,
    output logic                   out_valid,
    output logic [OCNT_W-1:0]      out_cnt,
    output logic                   out_last,
    output logic                   out_virt
);
    flush_state_t     st_q;
    logic             take;
    logic             sess_clr;
    logic [VEC_W-1:0] diff_vec;
    logic [VEC_W-1:0] q_vec;
    logic             q_full;
    logic             q_empty;
    logic             q_pop;
    logic             ser_busy;
    logic             s_valid;
    logic             s_bit;
    logic             s_ready;
    logic             enc_flush;
    logic             run_pending;
    logic             p_valid;
    logic             p_bit;
    logic             virt_q;
    logic             pack_fin;

    assign in_ready  = (st_q == FL_IDLE) && !q_full;
    assign take      = in_valid && in_ready;
    assign enc_flush = (st_q == FL_VIRT);
    assign pack_fin  = (st_q == FL_FINAL);
    assign sess_clr  = (st_q == FL_FINAL);

    trc_prep #(.VEC_W(VEC_W), .IDX_W(IDX_W)) prep_i (
        .clk(clk), .rst(rst), .perm_map(perm_map), .trace_in(trace_in),
        .take(take), .clr(sess_clr), .diff_vec(diff_vec)
    );

    trc_fifo #(.DATA_W(VEC_W), .DEPTH(FIFO_D)) fifo_i (
        .clk(clk), .rst(rst), .push(take), .wdata(diff_vec), .pop(q_pop),
        .rdata(q_vec), .full(q_full), .empty(q_empty)
    );

    trc_ser #(.VEC_W(VEC_W), .IDX_W(IDX_W)) ser_i (
        .clk(clk), .rst(rst), .vec_in(q_vec), .vec_avail(!q_empty),
        .vec_pop(q_pop), .clr(sess_clr), .busy(ser_busy),
        .bit_valid(s_valid), .bit_out(s_bit), .bit_ready(s_ready)
    );

    trc_fdr_enc #(.CNT_W(CNT_W)) enc_i (
        .clk(clk), .rst(rst), .bit_valid(s_valid), .bit_in(s_bit),
        .bit_ready(s_ready), .flush_go(enc_flush), .run_pending(run_pending),
        .pbit_valid(p_valid), .pbit(p_bit)
    );

    trc_pack #(.WORD_W(WORD_W), .OCNT_W(OCNT_W)) pack_i (
        .clk(clk), .rst(rst), .pbit_valid(p_valid), .pbit(p_bit),
        .fin(pack_fin), .fin_virt(virt_q), .out_word(out_word),
        .out_valid(out_valid), .out_cnt(out_cnt), .out_last(out_last),
        .out_virt(out_virt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= FL_IDLE;
            virt_q <= 1'b0;
        end else begin
            case (st_q)
                FL_IDLE:  if (flush_req) st_q <= FL_DRAIN;
                FL_DRAIN: if (q_empty && !ser_busy && s_ready) st_q <= FL_VIRT;
                FL_VIRT: begin
                    virt_q <= run_pending;
                    st_q   <= FL_WAIT;
                end
                FL_WAIT:  if (s_ready) st_q <= FL_FINAL;
                FL_FINAL: st_q <= FL_IDLE;
                default:  st_q <= FL_IDLE;
            endcase
        end
    end

    assert_flush_blocks_input_R9: assert property (@(posedge clk) disable iff (rst)
        (flush_req && st_q == FL_IDLE) |=> !in_ready);
    assert_virt_needs_run_R8: assert property (@(posedge clk) disable iff (rst)
        (out_last && out_virt) |-> (out_cnt != '0 || $past(out_valid)));

endmodule

// File: tb/trace_fdr_compressor_tb_top.sv
module trace_fdr_compressor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N       = 8;
    localparam int W       = 16;
    localparam int CW      = 5;
    localparam int IW      = 3;
    localparam int OW      = 5;
    localparam int RUN_CAP = 29;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N*IW-1:0] perm_map;
    logic [N-1:0]  trace_in = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          flush_req = 1'b0;
    logic [W-1:0]  out_word;
    logic          out_valid;
    logic [OW-1:0] out_cnt;
    logic          out_last;
    logic          out_virt;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int perm [N];
    logic [N-1:0] raw_q [$];
    logic [W-1:0] w_q [$];
    int           c_q [$];
    logic         got_last;
    logic         last_virt;
    int           stalls;

    trace_fdr_compressor #(.VEC_W(N), .WORD_W(W), .CNT_W(CW), .FIFO_D(2)) dut_i (
        .clk(clk), .rst(rst), .perm_map(perm_map), .trace_in(trace_in),
        .in_valid(in_valid), .in_ready(in_ready), .flush_req(flush_req),
        .out_word(out_word), .out_valid(out_valid), .out_cnt(out_cnt),
        .out_last(out_last), .out_virt(out_virt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (out_valid) begin
            w_q.push_back(out_word);
            c_q.push_back(int'(out_cnt));
            if (out_last) begin
                got_last  = 1'b1;
                last_virt = out_virt;
            end
        end
        if (in_valid && !in_ready) stalls++;
    end

    task automatic set_perm(input bit reversed);
        for (int i = 0; i < N; i++) begin
            perm[i] = reversed ? (N - 1 - i) : i;
            perm_map[i*IW +: IW] = IW'(perm[i]);
        end
    endtask

    task automatic set_perm_rot(input int k);
        for (int i = 0; i < N; i++) begin
            perm[i] = (i * 3 + k) % N;
            perm_map[i*IW +: IW] = IW'(perm[i]);
        end
    endtask

    task automatic begin_session();
        raw_q.delete();
        w_q.delete();
        c_q.delete();
        got_last  = 1'b0;
        last_virt = 1'b0;
        stalls    = 0;
    endtask

    task automatic send(input logic [N-1:0] v);
        trace_in = v;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        raw_q.push_back(v);
    endtask

    task automatic do_flush();
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        chk(in_ready == 1'b0, "R9 ready low during flush", in_ready, 0);
        for (int t = 0; t < 5000 && !got_last; t++) @(negedge clk);
        chk(got_last, "R8 last word seen", got_last, 1);
    endtask

    task automatic check_single(input string req, input logic [W-1:0] ew,
                                input int ec, input bit ev);
        chk(w_q.size() == 1, {req, " word count"}, w_q.size(), 1);
        if (w_q.size() == 1) begin
            chk(w_q[0] == ew, {req, " word"}, w_q[0], ew);
            chk(c_q[0] == ec, {req, " cnt"}, c_q[0], ec);
        end
        chk(last_virt == ev, {req, " virt"}, last_virt, ev);
    endtask

    // decode, undo reversal, differencing and mapping; compare with raw_q
    task automatic round_trip(input string name);
        bit bq [$];
        bit s [$];
        int p;
        int bad_full;
        logic [N-1:0] prev;
        bad_full = 0;
        for (int i = 0; i < w_q.size(); i++) begin
            if (i != w_q.size() - 1 && c_q[i] != W) bad_full++;
            for (int j = 0; j < c_q[i]; j++) bq.push_back(w_q[i][W-1-j]);
        end
        chk(bad_full == 0, {"R7 full words ", name}, bad_full, 0);
        p = 0;
        while (p < bq.size()) begin
            int ones;
            int tail;
            int r;
            ones = 0;
            while (p < bq.size() && bq[p]) begin ones++; p++; end
            p++;
            tail = 0;
            for (int b = 0; b <= ones; b++) begin
                tail = (tail << 1) | ((p < bq.size()) ? int'(bq[p]) : 0);
                p++;
            end
            r = (1 << (ones + 1)) - 2 + tail;
            for (int z = 0; z < r; z++) s.push_back(1'b0);
            if (r != RUN_CAP) s.push_back(1'b1);
        end
        if (last_virt && s.size() > 0) void'(s.pop_back());
        chk(s.size() == raw_q.size() * N, {"R10 length ", name}, s.size(), raw_q.size() * N);
        if (s.size() == raw_q.size() * N) begin
            prev = '0;
            for (int j = 0; j < raw_q.size(); j++) begin
                logic [N-1:0] d;
                logic [N-1:0] v;
                logic [N-1:0] raw;
                for (int b = 0; b < N; b++) d[(j % 2) ? (N - 1 - b) : b] = s[j*N + b];
                v = (j == 0) ? d : (d ^ prev);
                prev = v;
                for (int i = 0; i < N; i++) raw[perm[i]] = v[i];
                chk(raw == raw_q[j], {"R10 vector ", name}, raw, raw_q[j]);
            end
        end
    endtask

    task automatic t_reset();
        chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    endtask

    task automatic t_codeword();
        set_perm(1'b0);
        begin_session();
        send(8'h04);
        do_flush();
        check_single("R5 run2 + virtual run5", 16'h8B00, 8, 1'b1);
    endtask

    task automatic t_no_virtual();
        set_perm(1'b0);
        begin_session();
        send(8'h80);
        do_flush();
        check_single("R8 closed run, no virtual", 16'hC400, 6, 1'b0);
    endtask

    task automatic t_perm();
        set_perm(1'b1);
        begin_session();
        send(8'h20);
        do_flush();
        check_single("R2 reversed mapping", 16'h8B00, 8, 1'b1);
    endtask

    task automatic t_diff();
        set_perm(1'b0);
        begin_session();
        send(8'h01);
        send(8'h01);
        do_flush();
        check_single("R3 repeated vector differenced to zero", 16'h3840, 10, 1'b1);
    endtask

    task automatic t_reverse();
        set_perm(1'b0);
        begin_session();
        send(8'h01);
        send(8'h81);
        do_flush();
        check_single("R4 second vector reversed", 16'h31C4, 14, 1'b1);
    endtask

    task automatic t_saturate();
        set_perm(1'b0);
        begin_session();
        for (int i = 0; i < 5; i++) send(8'h00);
        do_flush();
        check_single("R6 saturated run", 16'hEFD4, 14, 1'b1);
    endtask

    task automatic t_stream(input string name, input int kind);
        logic [N-1:0] v;
        set_perm_rot(kind);
        begin_session();
        v = 8'h5A;
        for (int i = 0; i < 40; i++) begin
            case (kind)
                0: v = N'($urandom);
                1: v = '0;
                2: v = '1;
                default: if (i % 6 == 0) v[$urandom % N] = ~v[$urandom % N];
            endcase
            send(v);
        end
        chk(stalls > 0, {"R9 backpressure seen ", name}, stalls, 1);
        do_flush();
        round_trip(name);
    endtask

    initial begin
        set_perm(1'b0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_codeword();
        t_no_virtual();
        t_perm();
        t_diff();
        t_reverse();
        t_saturate();
        t_stream("random", 0);
        t_stream("all-zero", 1);
        t_stream("all-one", 2);
        t_stream("slow", 3);
        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule